// File: doc/BRIEF.md
# Address-Masked GPIO Data Port

This block is a general-purpose I/O port whose output data register can be updated pin by pin without a read-modify-write sequence. On the register bus the data register occupies a whole window of word-sized entries, one per possible pin subset. The word index inside that window is used as a pin mask. A write to an entry changes exactly the pins named by that index, and the other pins keep their values. Several pins can therefore be set and cleared in one bus write, and two agents that own different pins cannot corrupt each other's bits.

A read from the same window returns the current pin state at the masked positions and zero at every other position. A pin configured as an output reads back the value it drives. A pin configured as an input reads the pad level after a two-flop synchroniser. A separate direction register chooses output or input for each pin. The bus is a plain single-cycle register interface with registered read data.

Top module: `mgpio_port`

## Requirements
- R1: While reset is high, and at the first clock edge that samples reset high, the data register, the direction register (`pad_oe`), `pad_out` and `bus_rdata` are all cleared to zero, so every pin is an input.
- R2: A write (`bus_sel`=1, `bus_wr`=1) with `bus_addr[10]`=0 takes the mask m = `bus_addr[9:2]`. For every pin i with m[i]=1, the data bit i becomes `bus_wdata[i]` at that clock edge.
- R3: In such a write, data bits whose mask bit is 0, `bus_wdata[31:8]` and `bus_addr[1:0]` are ignored, and pins outside the mask keep their previous value.
- R4: A data write with mask 0x00 leaves `pad_out` unchanged.
- R5: A read (`bus_sel`=1, `bus_wr`=0) with `bus_addr[10]`=0 returns, in `bus_rdata[7:0]`, the pin value ANDed with mask m = `bus_addr[9:2]`. `bus_rdata[31:8]` is always zero.
- R6: The pin value is the driven data bit for a pin with direction 1 (output) and the synchronised pad level for a pin with direction 0 (input). A change on `pad_in` is first seen by a read latched at the third rising edge after the change.
- R7: The direction register sits at offset 0x400 (`bus_addr[10]`=1, `bus_addr[9:2]`=0). A write there loads `bus_wdata[7:0]` unmasked, and a read there returns it in bits [7:0]. Every other offset with `bus_addr[10]`=1 reads as zero and ignores writes.
- R8: `bus_rdata` is registered: it is updated at the edge that samples a read and holds its value in all other cycles.
- R9: `pad_out` always shows the data register and `pad_oe` the direction register. A 1 in the direction register means output.
- R10: Nothing changes when `bus_sel` is 0, whatever `bus_wr`, `bus_addr` and `bus_wdata` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 11 | Byte address; [9:2] pin mask, [10] selects the direction space |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | 8 | Pad levels, asynchronous |
| pad_out | output | 8 | Driven pin values |
| pad_oe | output | 8 | Per-pin output enable (direction) |

## Verification
The bench builds the port with its default parameters: eight pins, a 32-bit data word and an 11-bit address. With eight pins the whole mask space has only 256 entries, so the bench writes to every mask index against a running model of the output register. A scoreboard checks masked reads on a port with mixed directions, the exact synchroniser latency, the direction register space and its unmapped neighbours, and the read-data hold.

// File: rtl/mgpio_pkg.sv
package mgpio_pkg;
  typedef enum logic [1:0] {
    RGN_DATA = 2'd0,
    RGN_DIR  = 2'd1,
    RGN_NONE = 2'd2
  } rgn_e;
endpackage

// File: rtl/mgpio_decode.sv
module mgpio_decode
  import mgpio_pkg::*;
#(
  parameter int NPINS  = 8,
  parameter int ADDR_W = NPINS + 3
) (
  input  logic [ADDR_W-1:0] addr,
  output rgn_e              rgn,
  output logic [NPINS-1:0]  mask
);
  localparam int IDX_LO  = 2;
  localparam int IDX_HI  = IDX_LO + NPINS - 1;
  localparam int SPACE_B = IDX_HI + 1;

  always_comb begin
    mask = addr[IDX_HI:IDX_LO];
    if (!addr[SPACE_B])
      rgn = RGN_DATA;
    else if (mask == '0)
      rgn = RGN_DIR;
    else
      rgn = RGN_NONE;
  end
endmodule

// File: rtl/mgpio_sync.sv
module mgpio_sync #(
  parameter int NPINS  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] pad,
  output logic [NPINS-1:0] sync
);
  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst)
        chain <= '0;
      else
        chain <= {chain[STAGES-2:0], pad[p]};
    end
    assign sync[p] = chain[STAGES-1];
  end
endmodule

// File: rtl/mgpio_regs.sv
module mgpio_regs #(
  parameter int NPINS = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_data,
  input  logic             wr_dir,
  input  logic [NPINS-1:0] mask,
  input  logic [NPINS-1:0] wval,
  output logic [NPINS-1:0] data_q,
  output logic [NPINS-1:0] dir_q
);
  for (genvar p = 0; p < NPINS; p++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) begin
        data_q[p] <= 1'b0;
        dir_q[p]  <= 1'b0;
      end else begin
        if (wr_data && mask[p])
          data_q[p] <= wval[p];
        if (wr_dir)
          dir_q[p] <= wval[p];
      end
    end
  end
endmodule

// File: rtl/mgpio_port.sv
module mgpio_port
  import mgpio_pkg::*;
#(
  parameter int NPINS       = 8,
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = NPINS + 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NPINS-1:0]  pad_in,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_oe
);
  localparam int PAD_W = DATA_W - NPINS;

  rgn_e             rgn;
  logic [NPINS-1:0] mask;
  logic [NPINS-1:0] data_q;
  logic [NPINS-1:0] dir_q;
  logic [NPINS-1:0] pad_s;
  logic [NPINS-1:0] pin_val;
  logic [NPINS-1:0] rd_val;
  logic             wr_data;
  logic             wr_dir;
  logic             rd_en;

  mgpio_decode #(.NPINS(NPINS), .ADDR_W(ADDR_W)) i_decode (
    .addr (bus_addr),
    .rgn  (rgn),
    .mask (mask)
  );

  assign wr_data = bus_sel && bus_wr && (rgn == RGN_DATA);
  assign wr_dir  = bus_sel && bus_wr && (rgn == RGN_DIR);
  assign rd_en   = bus_sel && !bus_wr;

  mgpio_regs #(.NPINS(NPINS)) i_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_data (wr_data),
    .wr_dir  (wr_dir),
    .mask    (mask),
    .wval    (bus_wdata[NPINS-1:0]),
    .data_q  (data_q),
    .dir_q   (dir_q)
  );

  mgpio_sync #(.NPINS(NPINS), .STAGES(SYNC_STAGES)) i_sync (
    .clk  (clk),
    .rst  (rst),
    .pad  (pad_in),
    .sync (pad_s)
  );

  assign pin_val = (dir_q & data_q) | (~dir_q & pad_s);

  always_comb begin
    unique case (rgn)
      RGN_DATA: rd_val = pin_val & mask;
      RGN_DIR:  rd_val = dir_q;
      default:  rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)
      bus_rdata <= '0;
    else if (rd_en)
      bus_rdata <= {{PAD_W{1'b0}}, rd_val};
  end

  assign pad_out = data_q;
  assign pad_oe  = dir_q;
endmodule

// File: rtl/mgpio_port_chk.sv
module mgpio_port_chk #(
  parameter int NPINS  = 8,
  parameter int DATA_W = 32,
  parameter int ADDR_W = NPINS + 3
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [NPINS-1:0]  pad_out,
  input logic [NPINS-1:0]  pad_oe
);
  logic [NPINS-1:0] m;
  logic             dspace;
  logic             dwr;
  assign m      = bus_addr[NPINS+1:2];
  assign dspace = !bus_addr[NPINS+2];
  assign dwr    = bus_sel && bus_wr && dspace;

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (pad_out == '0 && pad_oe == '0 && bus_rdata == '0));

  // R2
  masked_set_chk: assert property (@(posedge clk) disable iff (rst)
    dwr |=> ((pad_out & $past(m)) == ($past(bus_wdata[NPINS-1:0]) & $past(m))));

  // R3
  unmasked_keep_chk: assert property (@(posedge clk) disable iff (rst)
    dwr |=> (((pad_out ^ $past(pad_out)) & ~$past(m)) == '0));

  // R4
  zero_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (dwr && m == '0) |=> $stable(pad_out));

  // R5
  upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    bus_rdata[DATA_W-1:NPINS] == '0);

  // R6
  out_readback_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && !bus_wr && dspace) |=>
      ((bus_rdata[NPINS-1:0] & $past(pad_oe & m)) == $past(pad_out & pad_oe & m)));

  // R8
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(bus_sel && !bus_wr) |=> $stable(bus_rdata));

  // R10
  idle_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_sel |=> ($stable(pad_out) && $stable(pad_oe)));
endmodule

bind mgpio_port mgpio_port_chk #(.NPINS(NPINS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .pad_out   (pad_out),
  .pad_oe    (pad_oe)
);

// File: tb/test_mgpio_port.sv
module test_mgpio_port;
  localparam int NPINS  = 8;
  localparam int DATA_W = 32;
  localparam int ADDR_W = NPINS + 3;
  localparam logic [ADDR_W-1:0] DIR_ADDR = 11'h400;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              bus_sel = 1'b0;
  logic              bus_wr = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [DATA_W-1:0] bus_wdata = '0;
  logic [DATA_W-1:0] bus_rdata;
  logic [NPINS-1:0]  pad_in = '0;
  logic [NPINS-1:0]  pad_out;
  logic [NPINS-1:0]  pad_oe;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  logic [DATA_W-1:0] exp_q[$];
  string             tag_q[$];

  logic [NPINS-1:0] m_out = '0;
  logic [NPINS-1:0] m_dir = '0;

  always #5 clk = ~clk;

  mgpio_port i_mgpio_port (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  task automatic chk(input string req, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [ADDR_W-1:0] daddr(input logic [NPINS-1:0] m);
    return {1'b0, m, 2'b00};
  endfunction

  function automatic logic [DATA_W-1:0] pinexp(input logic [NPINS-1:0] m);
    return {24'h0, ((m_dir & m_out) | (~m_dir & pad_in)) & m};
  endfunction

  task automatic bwrite(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bread(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] e, input string req);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    exp_q.push_back(e); tag_q.push_back(req);
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  // monitor: pops one expected item per sampled read
  initial begin
    forever begin
      @(posedge clk);
      if (!rst && bus_sel && !bus_wr) begin
        @(negedge clk);
        if (exp_q.size() == 0) begin
          chk("scoreboard-underflow", bus_rdata, 'x);
        end else begin
          chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      compared++; mismatched++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [DATA_W-1:0] held;
    repeat (3) @(negedge clk);
    // R1: reset values
    chk("R1 pad_out", {24'h0, pad_out}, 32'h0);
    chk("R1 pad_oe", {24'h0, pad_oe}, 32'h0);
    chk("R1 rdata", bus_rdata, 32'h0);
    @(negedge clk); rst = 1'b0;
    bread(daddr(8'hFF), 32'h0, "R1 read all inputs low");

    // R7/R9: direction register
    bwrite(DIR_ADDR, 32'hFFFF_FFFF); m_dir = 8'hFF;
    chk("R9 pad_oe", {24'h0, pad_oe}, 32'hFF);
    bread(DIR_ADDR, 32'hFF, "R7 dir readback");

    // R2: two-pin write with all data bits set
    bwrite(daddr(8'h44), 32'hFF); m_out = 8'h44;
    chk("R2 pins 2 and 6", {24'h0, pad_out}, 32'h44);
    bwrite(daddr(8'h04), 32'h0); m_out = 8'h40;
    chk("R2 clear pin 2", {24'h0, pad_out}, 32'h40);
    // R4: empty mask
    bwrite(daddr(8'h00), 32'hFFFF_FFFF);
    chk("R4 zero mask", {24'h0, pad_out}, 32'h40);
    // R3: unmasked data bits and byte offset ignored
    bwrite(daddr(8'h0F) | 11'h3, 32'hA5); m_out = 8'h45;
    chk("R3 low nibble", {24'h0, pad_out}, 32'h45);
    bwrite(daddr(8'hF0), 32'hFFFF_FF00); m_out = 8'h05;
    chk("R3 upper data ignored", {24'h0, pad_out}, 32'h05);

    // R10: write strobe without select
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b1; bus_addr = daddr(8'hFF); bus_wdata = 32'hFF;
    @(negedge clk);
    bus_wr = 1'b0;
    chk("R10 no select", {24'h0, pad_out}, 32'h05);
    chk("R10 dir kept", {24'h0, pad_oe}, 32'hFF);

    // R5/R6: reads of outputs through masks
    bread(daddr(8'h0F), 32'h05, "R5 mask 0F");
    bread(daddr(8'h01), 32'h01, "R5 mask 01");
    bread(daddr(8'hFA), 32'h00, "R5 mask FA");

    // R6: mixed directions
    bwrite(DIR_ADDR, 32'h0F); m_dir = 8'h0F;
    pad_in = 8'hA0;
    repeat (3) @(negedge clk);
    bread(daddr(8'hFF), pinexp(8'hFF), "R6 mixed read");
    bread(daddr(8'h30), pinexp(8'h30), "R6 input subset");

    // R6: synchroniser latency, pad and read issued together
    @(negedge clk);
    pad_in = 8'h50;
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = daddr(8'hF0);
    exp_q.push_back(32'hA0); tag_q.push_back("R6 latency edge1");
    @(negedge clk);
    exp_q.push_back(32'hA0); tag_q.push_back("R6 latency edge2");
    @(negedge clk);
    exp_q.push_back(32'h50); tag_q.push_back("R6 latency edge3");
    @(negedge clk);
    bus_sel = 1'b0;

    // R8: hold while idle and during writes
    @(negedge clk);
    held = bus_rdata;
    pad_in = 8'hFF;
    bwrite(daddr(8'hFF), 32'hCC); m_out = 8'hCC;
    repeat (3) @(negedge clk);
    chk("R8 rdata held", bus_rdata, held);

    // R7: unmapped direction-space offsets
    bwrite(11'h408, 32'h00);
    chk("R7 unmapped write ignored", {24'h0, pad_oe}, 32'h0F);
    bread(11'h404, 32'h0, "R7 unmapped read");

    // R2/R3: sweep every mask index
    for (int i = 0; i < 256; i++) begin
      logic [NPINS-1:0] mk;
      logic [DATA_W-1:0] w;
      mk = i[7:0];
      w  = (i * 32'h9E37_79B9) ^ 32'h5A5A_5A5A;
      bwrite(daddr(mk), w);
      m_out = (m_out & ~mk) | (w[7:0] & mk);
      chk("R2 R3 sweep", {24'h0, pad_out}, {24'h0, m_out});
    end
    bread(daddr(8'hFF), pinexp(8'hFF), "R5 after sweep");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) chk("scoreboard-leftover", exp_q.size(), 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule